// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Automatic Resend

This block sends single bytes to a smart card over one shared, open-drain I/O line. A host hands it a byte through a one-deep write port. The block frames the byte as a low start bit, eight data bits sent least significant bit first, and a parity bit. It then releases the line and listens for the card's error signal. If the card holds the line low in that window, the block sends the same byte again. It keeps doing so until the card accepts the byte or the programmed resend budget is used up. All bit timing is counted in ETUs, using a single-cycle tick input that pulses once per ETU. The line, the flags and the state all change only on the clock edge where that tick is high.

Between two accepted characters the block waits a programmable number of extra ETUs of guard time. Resends use a fixed spacing of 15 ETUs from start bit to start bit. The host watches a ready flag before each write. A one-cycle interrupt pulse tells the host that the holding slot has been emptied into the shifter. A byte written with the last-character mark sets a completion flag when that character is finished.

The controller is a five-state machine:
- IDLE: nothing to send.
- SEND: driving the ten frame bits.
- WINDOW: line released, error window sampled.
- RESEND_WAIT: waiting out the 15-ETU resend spacing.
- GAP: character spacing plus guard time.

Transitions:
- IDLE→SEND: on a tick while a byte is held.
- SEND→WINDOW: on the tick that ends the parity bit.
- WINDOW→RESEND_WAIT: on an error with budget left.
- WINDOW→GAP: on acceptance, or on an error with no budget left.
- RESEND_WAIT→SEND: on the 15th ETU after the previous start.
- GAP→SEND: when spacing is over and a byte is held.
- GAP→IDLE: when spacing is over and nothing is held.

Top module: `sct_char_tx`

## Requirements
- R1: After reset the line is released (`io_drive_low`=0), `tx_ready`=1, and `busy`, `tbe_irq`, `parity_err` and `last_done` are all 0.
- R2: A write (`wr_en`=1) while `tx_ready`=1 is stored, and `tx_ready` is 0 from the next cycle until the byte moves to the shifter. A write while `tx_ready`=0 is ignored: that byte is never sent.
- R3: A character is 10 ETUs of line drive: ETU 0 low (start bit), ETUs 1..8 carry data bit 0..7, and ETU 9 carries the parity bit. `io_drive_low`=1 means a 0 on the line. The line changes only in the cycle after a tick.
- R4: The parity bit is the XOR of the eight data bits (even parity) when `cfg_inv_parity`=0, and its inverse when `cfg_inv_parity`=1.
- R5: The line is released after the parity bit. `io_in` is sampled at the tick that ends ETU 10 (11 ETUs after the start bit). A low level there is an error signal.
- R6: On an error signal while the resends used so far are fewer than `cfg_retry_max`, the same byte is sent again. Its start bit begins exactly 15 ETUs after the previous start bit.
- R7: On an error signal with no resends left (including `cfg_retry_max`=0), `parity_err` becomes 1 and the byte is dropped. `parity_err` stays 1 until the next character is loaded.
- R8: After a character ends, the next start bit comes no earlier than 12 + `cfg_guard` ETUs after the last start bit. It comes exactly then if a byte is already held.
- R9: `tbe_irq` is a one-cycle pulse in the cycle the held byte moves into the shifter, which is the cycle its start bit appears. `tx_ready` returns to 1 in that same cycle.
- R10: When a character written with `wr_last`=1 finishes (accepted or dropped), `last_done` becomes 1. It clears when the next character is loaded.
- R11: `busy` is 1 from the load of a character until the block returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| etu_tick | input | 1 | One-cycle pulse per ETU |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to send |
| wr_last | input | 1 | Marks the byte as the last character |
| cfg_retry_max | input | 3 | Maximum number of resends per character |
| cfg_guard | input | 8 | Extra guard ETUs between characters |
| cfg_inv_parity | input | 1 | Selects inverted parity |
| io_in | input | 1 | Level observed on the card line |
| io_drive_low | output | 1 | Pull the card line low |
| tx_ready | output | 1 | A write can be accepted |
| tbe_irq | output | 1 | Byte moved to the shifter (pulse) |
| busy | output | 1 | A character is in progress |
| parity_err | output | 1 | Resend budget used up on a NAK |
| last_done | output | 1 | The marked last character has finished |

## Verification
Every result of a tick appears in the cycle right after the tick edge: the line level, the load pulse, the state flags, and the error and completion flags. A write shows on `tx_ready` one cycle after its strobe. The bench steps a behavioural model at each rising edge from the same inputs. At each falling edge it compares all six outputs with the model, so each value is checked half a cycle after it is due.

The card's error signal is driven from a falling-edge register during the whole WINDOW ETU. It is therefore stable at the tick that samples it. The sampled level sets only the flags and line values that follow that tick.

// File: rtl/sct_pkg.sv
package sct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WINDOW,
        ST_RESEND_WAIT,
        ST_GAP
    } sct_state_e;

    // Start-to-start spacing of a resent character, in ETU.
    localparam int RESEND_ETU = 15;
    // ETUs after the frame before a following character may start.
    localparam int TAIL_ETU   = 2;

endpackage

// File: rtl/sct_hold_buf.sv
module sct_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              last
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            last <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
            last <= wr_last;
        end
    end

endmodule

// File: rtl/sct_parity.sv
module sct_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              invert,
    output logic              par
);

    always_comb par = (^data) ^ invert;

endmodule

// File: rtl/sct_tx_fsm.sv
module sct_tx_fsm
    import sct_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RETRY_W = 3,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               etu_tick,
    input  logic               hold_full,
    input  logic [DATA_W-1:0]  hold_data,
    input  logic               hold_last,
    input  logic               par_bit,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic [GUARD_W-1:0] cfg_guard,
    input  logic               io_in,
    output logic               take,
    output logic [DATA_W-1:0]  cur_data,
    output logic               line_low,
    output logic               busy,
    output logic               load_pulse,
    output logic               perr,
    output logic               ldone
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int CNT_W      = GUARD_W + 2;
    localparam int PAR_POS    = FRAME_BITS - 1;
    localparam int SPACE_ETU  = FRAME_BITS + TAIL_ETU;

    sct_state_e         state, state_n;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-1:0]  shreg;
    logic               cur_last;
    logic [RETRY_W-1:0] used;
    logic               do_load, do_end, do_retry, do_err, restart;
    logic [CNT_W-1:0]   gap_limit;
    logic [(1<<IDX_W)-1:0] frame_ext;

    always_comb gap_limit = CNT_W'(SPACE_ETU - 1) + CNT_W'(cfg_guard);

    // Next-state process
    always_comb begin
        state_n  = state;
        do_load  = 1'b0;
        do_end   = 1'b0;
        do_retry = 1'b0;
        do_err   = 1'b0;
        restart  = 1'b0;
        if (etu_tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (hold_full) do_load = 1'b1;
                end
                ST_SEND: begin
                    if (cnt == CNT_W'(PAR_POS)) state_n = ST_WINDOW;
                end
                ST_WINDOW: begin
                    if (!io_in && (used < cfg_retry_max)) begin
                        do_retry = 1'b1;
                        state_n  = ST_RESEND_WAIT;
                    end else begin
                        do_err  = !io_in;
                        do_end  = 1'b1;
                        state_n = ST_GAP;
                    end
                end
                ST_RESEND_WAIT: begin
                    if (cnt == CNT_W'(RESEND_ETU - 1)) begin
                        restart = 1'b1;
                        state_n = ST_SEND;
                    end
                end
                ST_GAP: begin
                    if (cnt >= gap_limit) begin
                        if (hold_full) do_load = 1'b1;
                        else           state_n = ST_IDLE;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
        if (do_load) state_n = ST_SEND;
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            cur_last   <= 1'b0;
            used       <= '0;
            perr       <= 1'b0;
            ldone      <= 1'b0;
            load_pulse <= 1'b0;
        end else begin
            state      <= state_n;
            load_pulse <= do_load;
            if (etu_tick) begin
                if (do_load || restart) cnt <= '0;
                else if (state != ST_IDLE) cnt <= cnt + 1'b1;
            end
            if (do_load) begin
                shreg    <= hold_data;
                cur_last <= hold_last;
                used     <= '0;
                perr     <= 1'b0;
                ldone    <= 1'b0;
            end
            if (do_retry) used <= used + 1'b1;
            if (do_err) perr <= 1'b1;
            if (do_end && cur_last) ldone <= 1'b1;
        end
    end

    // Output process
    always_comb begin
        frame_ext = '1;
        frame_ext[FRAME_BITS-1:0] = {par_bit, shreg, 1'b0};
        line_low = 1'b0;
        if (state == ST_SEND && cnt <= CNT_W'(PAR_POS))
            line_low = !frame_ext[cnt[IDX_W-1:0]];
        busy     = (state != ST_IDLE);
        take     = do_load;
        cur_data = shreg;
    end

endmodule

// File: rtl/sct_char_tx.sv
module sct_char_tx #(
    parameter int DATA_W  = 8,
    parameter int RETRY_W = 3,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               etu_tick,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_last,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic [GUARD_W-1:0] cfg_guard,
    input  logic               cfg_inv_parity,
    input  logic               io_in,
    output logic               io_drive_low,
    output logic               tx_ready,
    output logic               tbe_irq,
    output logic               busy,
    output logic               parity_err,
    output logic               last_done
);

    logic              hold_full, hold_last, take, par_bit;
    logic [DATA_W-1:0] hold_data, cur_data;

    sct_hold_buf #(.DATA_W(DATA_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_last (wr_last),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data),
        .last    (hold_last)
    );

    sct_parity #(.DATA_W(DATA_W)) i_par (
        .data   (cur_data),
        .invert (cfg_inv_parity),
        .par    (par_bit)
    );

    sct_tx_fsm #(.DATA_W(DATA_W), .RETRY_W(RETRY_W), .GUARD_W(GUARD_W)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .etu_tick      (etu_tick),
        .hold_full     (hold_full),
        .hold_data     (hold_data),
        .hold_last     (hold_last),
        .par_bit       (par_bit),
        .cfg_retry_max (cfg_retry_max),
        .cfg_guard     (cfg_guard),
        .io_in         (io_in),
        .take          (take),
        .cur_data      (cur_data),
        .line_low      (io_drive_low),
        .busy          (busy),
        .load_pulse    (tbe_irq),
        .perr          (parity_err),
        .ldone         (last_done)
    );

    assign tx_ready = !hold_full;

endmodule

// File: rtl/sct_char_tx_chk.sv
module sct_char_tx_chk #(
    parameter int DATA_W  = 8,
    parameter int RETRY_W = 3,
    parameter int GUARD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               etu_tick,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic               wr_last,
    input logic [RETRY_W-1:0] cfg_retry_max,
    input logic [GUARD_W-1:0] cfg_guard,
    input logic               cfg_inv_parity,
    input logic               io_in,
    input logic               io_drive_low,
    input logic               tx_ready,
    input logic               tbe_irq,
    input logic               busy,
    input logic               parity_err,
    input logic               last_done
);

    // R3: the line moves only after a tick
    a_r3_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(etu_tick) |-> $stable(io_drive_low));

    // R11: driving implies busy
    a_r11_drive_busy: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive_low |-> busy);

    // R2: an accepted write drops ready
    a_r2_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && wr_en) |=> !tx_ready);

    // R9: load pulse frees the slot and is a single cycle
    a_r9_irq_frees: assert property (@(posedge clk) disable iff (!rst_n)
        tbe_irq |-> (tx_ready && busy));

    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        tbe_irq |=> !tbe_irq);

    // R7: the error flag is raised only by a tick
    a_r7_perr_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> $past(etu_tick));

endmodule

bind sct_char_tx sct_char_tx_chk #(.DATA_W(DATA_W), .RETRY_W(RETRY_W), .GUARD_W(GUARD_W)) i_chk (.*);

// File: tb/test_sct_char_tx.sv
`timescale 1ns/1ps
module test_sct_char_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       etu_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_last = 1'b0;
    logic [2:0] cfg_retry_max = '0;
    logic [7:0] cfg_guard = '0;
    logic       cfg_inv_parity = 1'b0;
    logic       io_in;
    logic       io_drive_low, tx_ready, tbe_irq, busy, parity_err, last_done;
    logic       card_low = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign io_in = !io_drive_low && !card_low;

    sct_char_tx i_sct_char_tx (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .wr_en(wr_en),
        .wr_data(wr_data), .wr_last(wr_last), .cfg_retry_max(cfg_retry_max),
        .cfg_guard(cfg_guard), .cfg_inv_parity(cfg_inv_parity), .io_in(io_in),
        .io_drive_low(io_drive_low), .tx_ready(tx_ready), .tbe_irq(tbe_irq),
        .busy(busy), .parity_err(parity_err), .last_done(last_done)
    );

    // behavioural reference model
    int       m_phase;   // 0 idle, 1 send, 2 window, 3 resend wait, 4 gap
    int       m_cnt, m_used, m_naks;
    bit [7:0] m_byte;
    bit       m_cur_last, m_perr, m_ldone, m_irq;
    bit [7:0] hold_q[$];
    bit       hold_last_q[$];
    int       naks_q[$];

    task automatic m_start();
        m_byte     = hold_q.pop_front();
        m_cur_last = hold_last_q.pop_front();
        m_naks     = (naks_q.size() > 0) ? naks_q.pop_front() : 0;
        m_perr = 0; m_ldone = 0; m_used = 0;
        m_phase = 1; m_cnt = 0; m_irq = 1;
    endtask

    always @(posedge clk) begin
        bit was_empty;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_used = 0; m_naks = 0;
            m_perr = 0; m_ldone = 0; m_irq = 0; m_cur_last = 0;
        end else begin
            was_empty = (hold_q.size() == 0);
            m_irq = 0;
            if (etu_tick) begin
                case (m_phase)
                    0: if (!was_empty) m_start();
                    1: begin
                        if (m_cnt == 9) m_phase = 2;
                        m_cnt++;
                    end
                    2: begin
                        m_cnt = 11;
                        if (card_low) begin
                            m_naks--;
                            if (m_used < int'(cfg_retry_max)) begin
                                m_used++; m_phase = 3;
                            end else begin
                                m_perr = 1; m_phase = 4;
                                if (m_cur_last) m_ldone = 1;
                            end
                        end else begin
                            m_phase = 4;
                            if (m_cur_last) m_ldone = 1;
                        end
                    end
                    3: begin
                        if (m_cnt == 14) begin m_phase = 1; m_cnt = 0; end
                        else m_cnt++;
                    end
                    default: begin
                        if (m_cnt >= 11 + int'(cfg_guard)) begin
                            if (!was_empty) m_start();
                            else m_phase = 0;
                        end else m_cnt++;
                    end
                endcase
            end
            if (wr_en && was_empty) begin
                hold_q.push_back(wr_data);
                hold_last_q.push_back(wr_last);
            end
        end
    end

    function automatic bit exp_line();
        if (m_phase != 1) return 1'b0;
        if (m_cnt == 0) return 1'b1;
        if (m_cnt <= 8) return !m_byte[m_cnt-1];
        return !((^m_byte) ^ cfg_inv_parity);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // falling edge: compare, then drive tick and card response
    always @(negedge clk) begin
        cyc++;
        if (cmp_on && rst_n) begin
            chk(io_drive_low == exp_line(), "R3/R4/R5/R6/R8 line", io_drive_low, exp_line());
            chk(tx_ready == (hold_q.size() == 0), "R2 tx_ready", tx_ready, hold_q.size() == 0);
            chk(tbe_irq == m_irq, "R9 tbe_irq", tbe_irq, m_irq);
            chk(busy == (m_phase != 0), "R11 busy", busy, m_phase != 0);
            chk(parity_err == m_perr, "R7 parity_err", parity_err, m_perr);
            chk(last_done == m_ldone, "R10 last_done", last_done, m_ldone);
        end
        etu_tick <= (cyc % 4 == 3);
        card_low <= (m_phase == 2) && (m_naks > 0);
    end

    task automatic put(input bit [7:0] b, input bit last, input int naks);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        wr_en = 1'b1; wr_data = b; wr_last = last;
        naks_q.push_back(naks);
        @(negedge clk);
        wr_en = 1'b0; wr_last = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_phase != 0 || hold_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(io_drive_low == 0, "R1 io_drive_low", io_drive_low, 0);
        chk(tx_ready == 1, "R1 tx_ready", tx_ready, 1);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(tbe_irq == 0, "R1 tbe_irq", tbe_irq, 0);
        chk(parity_err == 0, "R1 parity_err", parity_err, 0);
        chk(last_done == 0, "R1 last_done", last_done, 0);
        cmp_on = 1'b1;

        // R3 R4 plain even parity
        put(8'hA5, 0, 0);
        wait_idle();

        // R2 R8 back-to-back, plus a write while not ready
        put(8'h01, 0, 0);
        put(8'hFE, 0, 0);
        chk(tx_ready == 0, "R2 slot full", tx_ready, 0);
        wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();

        // R4 inverse parity
        cfg_inv_parity = 1'b1;
        put(8'h3C, 0, 0);
        put(8'h80, 0, 0);
        wait_idle();
        cfg_inv_parity = 1'b0;

        // R6 one NAK, then accepted
        cfg_retry_max = 3'd3;
        put(8'h5A, 0, 1);
        wait_idle();
        chk(parity_err == 0, "R6 no error after resend", parity_err, 0);

        // R7 budget used up
        cfg_retry_max = 3'd2;
        put(8'hC3, 0, 4);
        wait_idle();
        chk(parity_err == 1, "R7 error after limit", parity_err, 1);

        // R7 zero budget; R10 last flag on a dropped byte
        cfg_retry_max = 3'd0;
        put(8'h0F, 1, 1);
        wait_idle();
        chk(parity_err == 1, "R7 zero budget", parity_err, 1);
        chk(last_done == 1, "R10 last after drop", last_done, 1);

        // R8 guard time, R10 last on accepted byte, R6 with full budget
        cfg_retry_max = 3'd7;
        cfg_guard = 8'd5;
        put(8'h12, 0, 7);
        put(8'h34, 1, 0);
        wait_idle();
        chk(last_done == 1, "R10 last after accept", last_done, 1);
        chk(parity_err == 0, "R6 seven resends", parity_err, 0);

        cmp_on = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R11 actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule